// File: doc/BRIEF.md
# Vector Unit Access Trap Router

This block decides, for one access to the scalable vector unit, whether the access may go ahead and, if it may not, which privilege level (0 to 3) must take the trap. It looks at the current level, the vector-enable and floating-point-enable pairs held in the level-1 control register, the two trap bits held in the level-2 control register, the vector-enable bit held in the level-3 control register, and a set of platform flags: level 2 implemented, level 3 implemented, secure state, and host redirect. The decision is purely combinational.

A zero target means one of two things: the access is allowed, or a floating-point disable applies and a separate floating-point trap path handles it. The block does not tell these two cases apart; the caller runs the floating-point check on its own. Raising the exception is left to the surrounding logic.

A result stage can be chosen with a parameter. When it is present, a request strobe captures the decision and a valid strobe follows one cycle later. When it is absent, the stage is a pass-through.

Top module: `vec_trap_router`

## Requirements
- R1: The level-1 pair decode applies only when the current level is 0 or 1. The pair's bit 0 clear blocks levels 0 and 1. Bit 0 set with bit 1 clear blocks level 0 only. Both bits set block nothing. The vector pair `vec_en_i` is decoded first.
- R2: When the level-1 vector pair blocks, the target is 2 if `has_l2_i` is 1, `secure_i` is 0 and `host_redir_i` is 1. Otherwise the target is 1. No later check is consulted.
- R3: If the vector pair does not block, the floating-point pair `fp_en_i` is decoded in the same way. If it blocks, the target is 0 and no later check is consulted.
- R4: At levels 0 to 2 with `secure_i` at 0, `l2_vec_trap_i` set gives target 2. The trap bits are taken as given, because they read as zero when level 2 is absent.
- R5: In the same case, `l2_fp_trap_i` set gives target 0 and ends the evaluation. `l2_vec_trap_i` takes priority over it.
- R6: If `has_l3_i` is 1 and `l3_vec_en_i` is 0, the target is 3 at any level. This check is made only after all earlier checks have passed.
- R7: If no check traps, the target is 0.
- R8: With the result stage present, `vld_o` is 1 in the cycle after a cycle in which `req_i` was 1, and 0 otherwise. `tgt_q_o` then carries the decision for the inputs sampled with that request. `tgt_q_o` holds its value when there is no request.
- R9: During and right after reset, `vld_o` is 0 and `tgt_q_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe for the result stage |
| cur_lvl_i | input | LVL_W | Current privilege level |
| vec_en_i | input | 2 | Level-1 vector enable pair |
| fp_en_i | input | 2 | Level-1 floating-point enable pair |
| l2_vec_trap_i | input | 1 | Level-2 vector trap bit |
| l2_fp_trap_i | input | 1 | Level-2 floating-point trap bit |
| l3_vec_en_i | input | 1 | Level-3 vector enable bit |
| has_l2_i | input | 1 | Level 2 implemented |
| has_l3_i | input | 1 | Level 3 implemented |
| secure_i | input | 1 | Secure state |
| host_redir_i | input | 1 | Host redirect of level-1 traps |
| tgt_lvl_o | output | LVL_W | Combinational target level (0 = no vector trap) |
| tgt_q_o | output | LVL_W | Registered target level |
| vld_o | output | 1 | Registered target valid |

## Verification
The hardest cases to reach are those where an early rule hides a later one. Examples are a floating-point disable returning zero while level 3 would trap, and a secure caller losing the level-2 redirect even though host redirect is set. Purely random stimulus spreads thinly over such combinations. For that reason, the stimulus walks through all 8192 combinations of the thirteen decision input bits, including every current level. It then adds a seeded random phase with irregular request gaps to exercise holding and capture in the result stage.

// File: rtl/vtr_pkg.sv
package vtr_pkg;

   // Index of each enable pair in the decoder array; the order is the
   // evaluation priority (vector first, then floating point).
   localparam int unsigned PAIR_VEC  = 0;
   localparam int unsigned PAIR_FP   = 1;
   localparam int unsigned NUM_PAIRS = 2;
   localparam int unsigned PAIR_W    = 2;

   // Which rule settled a decision.
   typedef enum logic [2:0] {
      RULE_NONE   = 3'd0,
      RULE_L1_VEC = 3'd1,
      RULE_L1_FP  = 3'd2,
      RULE_L2_VEC = 3'd3,
      RULE_L2_FP  = 3'd4,
      RULE_L3_VEC = 3'd5
   } vtr_rule_e;

   typedef struct packed {
      logic l2_vec_trap;
      logic l2_fp_trap;
      logic l3_vec_en;
      logic has_l2;
      logic has_l3;
      logic secure;
      logic host_redir;
   } vtr_ctl_t;

endpackage

// File: rtl/vtr_pair_decode.sv
module vtr_pair_decode
   import vtr_pkg::*;
(
   input  logic [PAIR_W-1:0] en_i,
   input  logic              lvl_low_i,   // current level is 0 or 1
   input  logic              lvl_zero_i,  // current level is 0
   output logic              blocked_o
);

   logic all_off;
   logic user_off;

   // bit 0 clear: both low levels lose access
   assign all_off  = ~en_i[0];
   // bit 0 set, bit 1 clear: only level 0 loses access
   assign user_off = en_i[0] & ~en_i[1] & lvl_zero_i;

   assign blocked_o = lvl_low_i & (all_off | user_off);

endmodule

// File: rtl/vtr_priority.sv
module vtr_priority
   import vtr_pkg::*;
#(
   parameter int unsigned LVL_W = 2
) (
   input  logic [LVL_W-1:0] cur_lvl_i,
   input  logic             vec_blk_i,
   input  logic             fp_blk_i,
   input  vtr_ctl_t         ctl_i,
   output logic [LVL_W-1:0] tgt_o,
   output vtr_rule_e        rule_o
);

   localparam logic [LVL_W-1:0] LV0 = LVL_W'(0);
   localparam logic [LVL_W-1:0] LV1 = LVL_W'(1);
   localparam logic [LVL_W-1:0] LV2 = LVL_W'(2);
   localparam logic [LVL_W-1:0] LV3 = LVL_W'(3);

   logic l2_scope;
   logic redirect;

   // level-2 checks: levels 0..2 outside secure state
   assign l2_scope = (cur_lvl_i <= LV2) & ~ctl_i.secure;
   assign redirect = ctl_i.has_l2 & ~ctl_i.secure & ctl_i.host_redir;

   always_comb begin
      tgt_o  = LV0;
      rule_o = RULE_NONE;
      if (vec_blk_i) begin
         tgt_o  = redirect ? LV2 : LV1;
         rule_o = RULE_L1_VEC;
      end else if (fp_blk_i) begin
         tgt_o  = LV0;
         rule_o = RULE_L1_FP;
      end else if (l2_scope && ctl_i.l2_vec_trap) begin
         tgt_o  = LV2;
         rule_o = RULE_L2_VEC;
      end else if (l2_scope && ctl_i.l2_fp_trap) begin
         tgt_o  = LV0;
         rule_o = RULE_L2_FP;
      end else if (ctl_i.has_l3 && !ctl_i.l3_vec_en) begin
         tgt_o  = LV3;
         rule_o = RULE_L3_VEC;
      end
   end

endmodule

// File: rtl/vtr_out_stage.sv
module vtr_out_stage #(
   parameter int unsigned LVL_W   = 2,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic [LVL_W-1:0] d_i,
   output logic [LVL_W-1:0] q_o,
   output logic             vld_o
);

   generate
      if (OUT_REG) begin : g_reg
         logic [LVL_W-1:0] q_r;
         logic             vld_r;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q_r   <= '0;
               vld_r <= 1'b0;
            end else begin
               vld_r <= req_i;
               if (req_i) q_r <= d_i;
            end
         end

         assign q_o   = q_r;
         assign vld_o = vld_r;

         p_vld_after_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
            req_i |=> vld_o);
         p_vld_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !req_i |=> !vld_o);
         p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
            req_i |=> (q_o == $past(d_i)));
         p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !req_i |=> $stable(q_o));
      end else begin : g_pass
         assign q_o   = d_i;
         assign vld_o = req_i;
      end
   endgenerate

endmodule

// File: rtl/vec_trap_router.sv
module vec_trap_router
   import vtr_pkg::*;
#(
   parameter int unsigned LVL_W   = 2,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic [LVL_W-1:0] cur_lvl_i,
   input  logic [1:0]       vec_en_i,
   input  logic [1:0]       fp_en_i,
   input  logic             l2_vec_trap_i,
   input  logic             l2_fp_trap_i,
   input  logic             l3_vec_en_i,
   input  logic             has_l2_i,
   input  logic             has_l3_i,
   input  logic             secure_i,
   input  logic             host_redir_i,
   output logic [LVL_W-1:0] tgt_lvl_o,
   output logic [LVL_W-1:0] tgt_q_o,
   output logic             vld_o
);

   localparam logic [LVL_W-1:0] LV0 = LVL_W'(0);
   localparam logic [LVL_W-1:0] LV1 = LVL_W'(1);
   localparam logic [LVL_W-1:0] LV2 = LVL_W'(2);
   localparam logic [LVL_W-1:0] LV3 = LVL_W'(3);

   generate
      if (LVL_W < 2) begin : g_bad_width
         $error("vec_trap_router: LVL_W must be at least 2");
      end
      if (PAIR_W != 2) begin : g_bad_pair
         $error("vec_trap_router: enable pairs must be two bits wide");
      end
   endgenerate

   logic [NUM_PAIRS-1:0][PAIR_W-1:0] pair_en;
   logic [NUM_PAIRS-1:0]             pair_blk;
   logic                             lvl_low;
   logic                             lvl_zero;
   vtr_ctl_t                         ctl;
   vtr_rule_e                        rule;

   assign pair_en[PAIR_VEC] = vec_en_i;
   assign pair_en[PAIR_FP]  = fp_en_i;
   assign lvl_low  = (cur_lvl_i <= LV1);
   assign lvl_zero = (cur_lvl_i == LV0);

   assign ctl = '{l2_vec_trap: l2_vec_trap_i, l2_fp_trap: l2_fp_trap_i,
                  l3_vec_en: l3_vec_en_i, has_l2: has_l2_i, has_l3: has_l3_i,
                  secure: secure_i, host_redir: host_redir_i};

   generate
      for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
         vtr_pair_decode u_dec (
            .en_i       (pair_en[g]),
            .lvl_low_i  (lvl_low),
            .lvl_zero_i (lvl_zero),
            .blocked_o  (pair_blk[g])
         );
      end
   endgenerate

   vtr_priority #(.LVL_W(LVL_W)) u_prio (
      .cur_lvl_i (cur_lvl_i),
      .vec_blk_i (pair_blk[PAIR_VEC]),
      .fp_blk_i  (pair_blk[PAIR_FP]),
      .ctl_i     (ctl),
      .tgt_o     (tgt_lvl_o),
      .rule_o    (rule)
   );

   vtr_out_stage #(.LVL_W(LVL_W), .OUT_REG(OUT_REG)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .req_i (req_i),
      .d_i   (tgt_lvl_o),
      .q_o   (tgt_q_o),
      .vld_o (vld_o)
   );

   // A vector block from the level-1 pair always lands on level 1 or 2.
   p_vec_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pair_blk[PAIR_VEC] |-> (tgt_lvl_o == LV1 || tgt_lvl_o == LV2));
   // Secure state never takes the redirect to level 2.
   p_secure_no_redirect_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_blk[PAIR_VEC] && secure_i) |-> (tgt_lvl_o == LV1));
   // A pair decode never fires above level 1.
   p_pair_scope_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_lvl_i > LV1) |-> (pair_blk == '0));
   // Level-2 vector trap outranks the floating-point trap bit.
   p_l2_vec_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_blk == '0 && cur_lvl_i <= LV2 && !secure_i && l2_vec_trap_i)
      |-> (tgt_lvl_o == LV2));
   // At level 3 only the level-3 rule can trap.
   p_top_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_lvl_i == LV3) |-> (tgt_lvl_o == LV0 || tgt_lvl_o == LV3));
   // Level-3 target comes only from its own rule.
   p_l3_rule_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_lvl_o == LV3) |-> (rule == RULE_L3_VEC && has_l3_i && !l3_vec_en_i));

endmodule

// File: tb/sim_vec_trap_router.sv
module sim_vec_trap_router;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_i = 1'b0;
   logic [1:0] cur_lvl_i = '0;
   logic [1:0] vec_en_i = '0;
   logic [1:0] fp_en_i = '0;
   logic       l2_vec_trap_i = 1'b0, l2_fp_trap_i = 1'b0, l3_vec_en_i = 1'b0;
   logic       has_l2_i = 1'b0, has_l3_i = 1'b0, secure_i = 1'b0, host_redir_i = 1'b0;
   logic [1:0] tgt_lvl_o, tgt_q_o;
   logic       vld_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   vec_trap_router #(.LVL_W(2), .OUT_REG(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .cur_lvl_i(cur_lvl_i),
      .vec_en_i(vec_en_i), .fp_en_i(fp_en_i), .l2_vec_trap_i(l2_vec_trap_i),
      .l2_fp_trap_i(l2_fp_trap_i), .l3_vec_en_i(l3_vec_en_i),
      .has_l2_i(has_l2_i), .has_l3_i(has_l3_i), .secure_i(secure_i),
      .host_redir_i(host_redir_i), .tgt_lvl_o(tgt_lvl_o), .tgt_q_o(tgt_q_o),
      .vld_o(vld_o));

   // Expected decision from the requirements; tag names the deciding rule.
   function automatic logic [1:0] ref_tgt(input logic [12:0] v, output string tag);
      logic [1:0] cur, ve, fe;
      logic t2v, t2f, e3, h2, h3, sec, hr, vb, fb;
      cur = v[1:0]; ve = v[3:2]; fe = v[5:4];
      t2v = v[6]; t2f = v[7]; e3 = v[8]; h2 = v[9]; h3 = v[10]; sec = v[11]; hr = v[12];
      if (cur <= 2'd1) begin
         vb = !ve[0] || (!ve[1] && cur == 2'd0);
         if (vb) begin tag = "R2"; return (h2 && !sec && hr) ? 2'd2 : 2'd1; end
         fb = !fe[0] || (!fe[1] && cur == 2'd0);
         if (fb) begin tag = "R3"; return 2'd0; end
      end
      if (cur <= 2'd2 && !sec) begin
         if (t2v) begin tag = "R4"; return 2'd2; end
         if (t2f) begin tag = "R5"; return 2'd0; end
      end
      if (h3 && !e3) begin tag = "R6"; return 2'd3; end
      tag = (cur <= 2'd1) ? "R1" : "R7";
      return 2'd0;
   endfunction

   task automatic apply(input logic [12:0] v);
      cur_lvl_i = v[1:0]; vec_en_i = v[3:2]; fp_en_i = v[5:4];
      l2_vec_trap_i = v[6]; l2_fp_trap_i = v[7]; l3_vec_en_i = v[8];
      has_l2_i = v[9]; has_l3_i = v[10]; secure_i = v[11]; host_redir_i = v[12];
   endtask

   task automatic check(input string req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   logic       pend_req = 1'b0;
   logic [1:0] pend_exp = '0;
   logic [1:0] held_q = '0;

   // One stimulus cycle: check the previous request, drive new inputs, check comb.
   task automatic step(input logic [12:0] v, input logic rq);
      string tag;
      logic [1:0] e;
      @(negedge clk);
      check("R8", vld_o, pend_req, "vld_o");
      if (pend_req) held_q = pend_exp;
      check("R8", tgt_q_o, held_q, "tgt_q_o");
      apply(v);
      req_i = rq;
      #1;
      e = ref_tgt(v, tag);
      check(tag, tgt_lvl_o, e, "tgt_lvl_o");
      pend_req = rq;
      pend_exp = e;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         errors++;
         $display("FAIL R8 watchdog: actual=%0d cycles expected<150000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      check("R9", vld_o, 0, "vld_o in reset");
      check("R9", tgt_q_o, 0, "tgt_q_o in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R9", vld_o, 0, "vld_o after reset");
      check("R9", tgt_q_o, 0, "tgt_q_o after reset");

      // Directed corners: fp disable hides a level-3 trap (R3), secure
      // blocks redirect (R2), level-2 vector trap beats fp trap (R5).
      step(13'b0_0_1_0_0_1_1_00_11_00, 1'b1); // R3: level 0, fp pair off, L3 would trap
      step(13'b1_1_0_1_0_0_0_00_00_01, 1'b1); // R2: secure with redirect -> 1
      step(13'b1_0_0_1_0_1_1_11_11_10, 1'b0); // R5: level 2, both L2 traps -> 2
      step(13'b0_0_1_0_0_0_0_11_11_11, 1'b1); // R6: level 3, L3 disabled -> 3
      step(13'b0_0_1_0_1_0_0_11_11_11, 1'b0); // R7: level 3 all enabled -> 0

      // Exhaustive walk of all decision inputs (R1..R7) with random requests (R8).
      for (int i = 0; i < 8192; i++) step(13'(i), 1'($urandom % 2));

      // Random phase with sparse requests.
      for (int i = 0; i < 3000; i++) step(13'($urandom), ($urandom % 4) == 0);

      @(negedge clk);
      check("R8", vld_o, pend_req, "vld_o final");
      if (pend_req) held_q = pend_exp;
      check("R8", tgt_q_o, held_q, "tgt_q_o final");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule